// File: doc/BRIEF.md
# Clock wake-up delay and divider

This block sits in the oscillator clock domain and produces the enable that paces a processor core. After a synchronous reset or a wake request it keeps the core enable low for a stabilization interval. The length of that interval depends on which clock source is selected. Crystal sources need a cycle count plus a fixed time. The on-chip RC oscillator needs only a fixed time. The watchdog oscillator and an external clock need only a short cycle count. Fixed times are converted to oscillator cycles through a cycles-per-microsecond parameter.

Once the interval ends, the block emits a train of single-cycle enable pulses. The pulse spacing is set by an 8-bit divide register that software may rewrite at any moment. A new value only takes effect at a pulse boundary, so every period is either a complete old one or a complete new one. A separate low-power flag bit is cleared by reset and otherwise follows software writes.

Top module: `clk_wake_div`

## Requirements
- R1: With source code 000 (external clock), 001 (watchdog oscillator), 110 or 111, the stabilization interval is 32 oscillator cycles.
- R2: With source code 010 (RC oscillator), the stabilization interval is RC_US*CYC_PER_US cycles (250 us; 500 cycles with the default CYC_PER_US=2).
- R3: With source codes 011, 100 or 101 (crystal low, medium, high), the interval is XTAL_CYC+XTAL_US*CYC_PER_US cycles (1024 cycles plus 80 us; 1184 with defaults).
- R4: If reset or wake_req is last sampled high on clock edge c0 with an interval of N cycles, then `ready` and `clk_en` are low through edge c0+N-1, and both go high together on edge c0+N. The source code is captured at the restart edge, so later changes of src_sel do not alter the running interval.
- R5: While ready, clk_en pulses once every 2*D cycles, where D is the divide register. D=0 gives a pulse every cycle, and D=255 gives the maximum spacing of 510 cycles.
- R6: A divide write takes effect at a pulse boundary. A pulse issued on an edge uses the register value held just before that edge. The period that follows that pulse then runs in full with that value, so there are no shortened, stretched or extra pulses.
- R7: A wake_req sampled high makes ready and clk_en low on the next edge and restarts the interval.
- R8: low_power is 0 after reset. It loads lp_din on an edge where lp_we is high and otherwise holds its value, including across wake requests.
- R9: Reset also clears the divide register to 0 and starts an interval exactly as a wake request does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| wake_req | input | 1 | Restarts the stabilization interval |
| src_sel | input | 3 | Clock source code, captured at restart |
| div_val | input | DIV_W | New divide register value |
| div_we | input | 1 | Write strobe for div_val |
| lp_we | input | 1 | Write strobe for the low-power flag |
| lp_din | input | 1 | Value written to the low-power flag |
| clk_en | output | 1 | Single-cycle core clock enable pulse |
| ready | output | 1 | High once the interval is complete |
| low_power | output | 1 | Low-power flag |

## Verification
On every cycle, the assertions check the following. clk_en never appears without ready. The first pulse coincides with the rise of ready. A wake request clears both outputs on the next edge. The low-power flag is cleared by reset and moves only on a write strobe. Each gap between pulses matches the divide value that was in force at the previous pulse, with no pulse arriving early. The exact interval length for each source code, the capture of the source at restart, and the clearing of the divide register by reset can only be shown by the bench. It does this by predicting the absolute cycle of every pulse and comparing the predictions in a scoreboard.

// File: rtl/cwd_pkg.sv
package cwd_pkg;
  localparam logic [2:0] SRC_EXT  = 3'd0;
  localparam logic [2:0] SRC_WDOG = 3'd1;
  localparam logic [2:0] SRC_RC   = 3'd2;
  localparam logic [2:0] SRC_XLO  = 3'd3;
  localparam logic [2:0] SRC_XMID = 3'd4;
  localparam logic [2:0] SRC_XHI  = 3'd5;

  // Stabilization length in oscillator cycles for a source code (R1, R2, R3)
  function automatic int unsigned stab_cycles(input logic [2:0] src,
                                              input int unsigned cyc_per_us,
                                              input int unsigned xtal_cyc,
                                              input int unsigned xtal_us,
                                              input int unsigned rc_us,
                                              input int unsigned fast_cyc);
    int unsigned n;
    case (src)
      SRC_RC:                     n = rc_us * cyc_per_us;
      SRC_XLO, SRC_XMID, SRC_XHI: n = xtal_cyc + xtal_us * cyc_per_us;
      default:                    n = fast_cyc;
    endcase
    return n;
  endfunction

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/cwd_wake_timer.sv
module cwd_wake_timer
  import cwd_pkg::*;
#(
  parameter int unsigned CYC_PER_US = 2,
  parameter int unsigned XTAL_CYC   = 1024,
  parameter int unsigned XTAL_US    = 80,
  parameter int unsigned RC_US      = 250,
  parameter int unsigned FAST_CYC   = 32
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wake_req,
  input  logic [2:0] src_sel,
  output logic       ready,
  output logic       ready_nxt
);
  localparam int unsigned MAX_DLY = max3(XTAL_CYC + XTAL_US * CYC_PER_US,
                                         RC_US * CYC_PER_US, FAST_CYC);
  localparam int unsigned CW = $clog2(MAX_DLY + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] tgt_q;
  logic          ready_q;
  logic          restart;

  assign restart = rst | wake_req;

  always_comb begin
    if (restart)      ready_nxt = 1'b0;
    else if (ready_q) ready_nxt = 1'b1;
    else              ready_nxt = (cnt_q == tgt_q - 1'b1);
  end

  always_ff @(posedge clk) begin
    if (restart) begin
      cnt_q   <= '0;
      tgt_q   <= CW'(stab_cycles(src_sel, CYC_PER_US, XTAL_CYC, XTAL_US, RC_US, FAST_CYC));
      ready_q <= 1'b0;
    end else begin
      ready_q <= ready_nxt;
      if (!ready_q) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign ready = ready_q;
endmodule

// File: rtl/cwd_divider.sv
module cwd_divider #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div_val,
  input  logic             div_we,
  output logic             clk_en
);
  localparam int unsigned PW = DIV_W + 1;

  logic [DIV_W-1:0] div_q;
  logic [PW-1:0]    cnt_q;
  logic             en_q;

  // Cycles left after a pulse: 2*D-1, or 0 when D is 0
  function automatic logic [PW-1:0] gap_m1(input logic [DIV_W-1:0] d);
    return (d == '0) ? '0 : ({d, 1'b0} - PW'(1));
  endfunction

  always_ff @(posedge clk) begin
    if (rst)         div_q <= '0;
    else if (div_we) div_q <= div_val;
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
      en_q  <= 1'b0;
    end else if (cnt_q == '0) begin
      en_q  <= 1'b1;
      cnt_q <= gap_m1(div_q);
    end else begin
      en_q  <= 1'b0;
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign clk_en = en_q;
endmodule

// File: rtl/cwd_lp_flag.sv
module cwd_lp_flag (
  input  logic clk,
  input  logic rst,
  input  logic lp_we,
  input  logic lp_din,
  output logic low_power
);
  logic flag_q;

  always_ff @(posedge clk) begin
    if (rst)        flag_q <= 1'b0;
    else if (lp_we) flag_q <= lp_din;
  end

  assign low_power = flag_q;
endmodule

// File: rtl/clk_wake_div.sv
module clk_wake_div #(
  parameter int unsigned CYC_PER_US = 2,
  parameter int unsigned XTAL_CYC   = 1024,
  parameter int unsigned XTAL_US    = 80,
  parameter int unsigned RC_US      = 250,
  parameter int unsigned FAST_CYC   = 32,
  parameter int unsigned DIV_W      = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wake_req,
  input  logic [2:0]       src_sel,
  input  logic [DIV_W-1:0] div_val,
  input  logic             div_we,
  input  logic             lp_we,
  input  logic             lp_din,
  output logic             clk_en,
  output logic             ready,
  output logic             low_power
);
  logic run_nxt;

  cwd_wake_timer #(
    .CYC_PER_US(CYC_PER_US), .XTAL_CYC(XTAL_CYC), .XTAL_US(XTAL_US),
    .RC_US(RC_US), .FAST_CYC(FAST_CYC)
  ) u_timer (
    .clk(clk), .rst(rst), .wake_req(wake_req), .src_sel(src_sel),
    .ready(ready), .ready_nxt(run_nxt)
  );

  cwd_divider #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .run(run_nxt), .div_val(div_val),
    .div_we(div_we), .clk_en(clk_en)
  );

  cwd_lp_flag u_lp (
    .clk(clk), .rst(rst), .lp_we(lp_we), .lp_din(lp_din), .low_power(low_power)
  );
endmodule

// File: rtl/cwd_checker.sv
module cwd_checker #(
  parameter int unsigned DIV_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             wake_req,
  input logic [DIV_W-1:0] div_val,
  input logic             div_we,
  input logic             lp_we,
  input logic             clk_en,
  input logic             ready,
  input logic             low_power
);
  logic [DIV_W-1:0] sh_q, sh_prev_q;
  logic [15:0]      gap_q, exp_q;
  logic             have_q;

  // Port-level shadow of the divide register and spacing since the last pulse
  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q <= '0; sh_prev_q <= '0; gap_q <= '0; exp_q <= '0; have_q <= 1'b0;
    end else begin
      if (div_we) sh_q <= div_val;
      sh_prev_q <= sh_q;
      if (!ready) begin
        have_q <= 1'b0;
        gap_q  <= '0;
      end else if (clk_en) begin
        have_q <= 1'b1;
        gap_q  <= 16'd1;
        exp_q  <= (sh_prev_q == '0) ? 16'd1 : 16'({sh_prev_q, 1'b0});
      end else begin
        gap_q <= gap_q + 16'd1;
      end
    end
  end

  assert_en_needs_ready_R4: assert property (@(posedge clk) disable iff (rst)
    clk_en |-> ready);
  assert_first_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> clk_en);
  assert_wake_clears_R7: assert property (@(posedge clk) disable iff (rst)
    wake_req |=> (!ready && !clk_en));
  assert_lp_reset_R8: assert property (@(posedge clk)
    rst |=> !low_power);
  assert_lp_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !lp_we |=> $stable(low_power));
  assert_gap_exact_R6: assert property (@(posedge clk) disable iff (rst)
    (have_q && ready && clk_en) |-> (gap_q == exp_q));
  assert_no_early_R5: assert property (@(posedge clk) disable iff (rst)
    (have_q && ready && !clk_en) |-> (gap_q < exp_q));
endmodule

bind clk_wake_div cwd_checker #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst(rst), .wake_req(wake_req), .div_val(div_val), .div_we(div_we),
  .lp_we(lp_we), .clk_en(clk_en), .ready(ready), .low_power(low_power)
);

// File: tb/clk_wake_div_tb.sv
module clk_wake_div_tb;
  localparam int CPU = 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wake_req = 1'b0;
  logic [2:0] src_sel = 3'd0;
  logic [7:0] div_val = 8'd0;
  logic       div_we = 1'b0;
  logic       lp_we = 1'b0;
  logic       lp_din = 1'b0;
  logic       clk_en, ready, low_power;

  always #4 clk = ~clk;

  clk_wake_div #(.CYC_PER_US(CPU)) u_dut (
    .clk(clk), .rst(rst), .wake_req(wake_req), .src_sel(src_sel),
    .div_val(div_val), .div_we(div_we), .lp_we(lp_we), .lp_din(lp_din),
    .clk_en(clk_en), .ready(ready), .low_power(low_power)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int  n_chk = 0;
  int  n_fail = 0;
  int  q[$];
  bit  done = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Scoreboard monitor: every pulse must match the next predicted cycle
  always @(negedge clk) begin
    if (clk_en) begin
      if (q.size() == 0) chk(1'b0, "R5 unexpected clk_en pulse at cycle", cyc, -1);
      else begin
        int e;
        e = q.pop_front();
        chk(cyc == e, "R5/R6 clk_en pulse cycle", cyc, e);
      end
    end
  end

  function automatic int dly(input int s);
    case (s)
      2:       return 250 * CPU;            // R2
      3, 4, 5: return 1024 + 80 * CPU;      // R3
      default: return 32;                   // R1
    endcase
  endfunction

  function automatic int per(input int d);
    return (d == 0) ? 1 : 2 * d;
  endfunction

  task automatic wait_cyc(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic wr_div(input int d);
    div_we = 1'b1; div_val = 8'(d);
    @(negedge clk);
    div_we = 1'b0;
  endtask

  // Driver: predicts ready timing and pulse cycles, runs one interval, then restarts
  task automatic phase(input int c0, input int src, input int d1, input int wcyc,
                       input int d2, input int span, input int nsrc, input string tag);
    int first, last, p;
    first = c0 + dly(src);
    last  = first + span;
    p = first;
    while (p <= last) begin
      q.push_back(p);
      p += per((wcyc > 0 && p >= wcyc + 2) ? d2 : d1);
    end
    wait_cyc(c0);
    chk(ready == 1'b0, {tag, " ready low after restart"}, ready, 0);
    wait_cyc(first - 1);
    chk(ready == 1'b0 && clk_en == 1'b0, {tag, " still held one cycle before end"}, ready, 0);
    wait_cyc(first);
    chk(ready == 1'b1, {tag, " ready high at interval end"}, ready, 1);
    if (wcyc > 0) begin
      wait_cyc(wcyc);
      wr_div(d2);
    end
    wait_cyc(last);
    wake_req = 1'b1; src_sel = 3'(nsrc);
    @(negedge clk);
    wake_req = 1'b0;
    chk(ready == 1'b0 && clk_en == 1'b0, "R7 wake clears ready and clk_en", ready, 0);
    chk(q.size() == 0, {tag, " R6 all predicted pulses seen"}, q.size(), 0);
    q.delete();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R4 watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int c0;
    repeat (5) @(negedge clk);
    chk(ready == 1'b0 && clk_en == 1'b0, "R9 outputs low in reset", ready, 0);
    chk(low_power == 1'b0, "R8 low_power cleared by reset", low_power, 0);
    rst = 1'b0;
    c0 = cyc;
    // R1 external source, R5 divide 0 gives a pulse each cycle
    phase(c0, 0, 0, 0, 0, 9, 1, "R1/R4 ext");
    c0 = cyc;
    wr_div(3);
    phase(c0, 1, 3, 0, 3, 30, 2, "R1 wdog div3");
    // R2 RC source, R6 divide change 1 -> 5 mid run
    c0 = cyc;
    wr_div(1);
    phase(c0, 2, 1, c0 + dly(2) + 7, 5, 40, 3, "R2/R6 rc");
    // R3 crystal low, R5 maximum division 510
    c0 = cyc;
    wr_div(255);
    phase(c0, 3, 255, 0, 255, 1020, 4, "R3/R5 xlo max div");
    c0 = cyc;
    wr_div(0);
    phase(c0, 4, 0, 0, 0, 3, 5, "R3 xmid");
    c0 = cyc;
    phase(c0, 5, 0, 0, 0, 3, 6, "R3 xhi");
    c0 = cyc;
    phase(c0, 6, 0, 0, 0, 3, 7, "R1 code6");
    // R4 source captured at restart: change src_sel during the interval
    c0 = cyc;
    src_sel = 3'd2;
    phase(c0, 7, 0, 0, 0, 3, 0, "R1/R4 code7 latched");
    // R8 low-power flag
    lp_we = 1'b1; lp_din = 1'b1;
    @(negedge clk);
    lp_we = 1'b0; lp_din = 1'b0;
    chk(low_power == 1'b1, "R8 low_power set by write", low_power, 1);
    wake_req = 1'b1;
    @(negedge clk);
    wake_req = 1'b0;
    chk(low_power == 1'b1, "R8 wake keeps low_power", low_power, 1);
    @(negedge clk);
    chk(low_power == 1'b1, "R8 lp_din ignored without strobe", low_power, 1);
    wr_div(200);
    // R9 reset clears divide register and restarts the interval
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk(low_power == 1'b0, "R8 reset clears low_power", low_power, 0);
    rst = 1'b0;
    c0 = cyc;
    phase(c0, 0, 0, 0, 0, 4, 0, "R9 after reset div 0");
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule